// File: doc/BRIEF.md
# Physical Register Busy Table

This block is a scoreboard with one bit per physical register of an out-of-order core. The bit shows whether the value for that register is still pending. A register becomes busy in the cycle after the rename stage takes it from the free list as a fresh destination. It becomes ready again in the cycle after its producing instruction writes the result back.

Decode looks up one bit per source operand on several independent read ports. These lookups are combinational. The decoder copies the returned bits into the instruction queue, so any change that comes later must reach the queue over the wakeup path.

A write-back that lands in the same cycle as a lookup of the same register is forwarded to that lookup. A flush input lets recovery logic drop every pending register except the ones named in a keep mask.

Top module: `pbt_busy_table`

## Requirements
- R1: After a synchronous active-high reset, every register reads not-busy (0) on every read port.
- R2: A valid allocate port makes its register read busy (1) from the next clock edge onward. An allocate port whose valid bit is 0 changes nothing.
- R3: A valid write-back port makes its register read not-busy from the next clock edge onward. A write-back port whose valid bit is 0 changes nothing.
- R4: If an allocation and a write-back name the same register in one cycle, the register is busy afterwards.
- R5: Each of the four read ports returns, in the same cycle, the bit of the register number on that port. The ports are independent of each other.
- R6: A read of a register that a valid write-back names in the same cycle returns not-busy.
- R7: An allocation is not forwarded. A read in the allocation cycle returns the state from before the allocation.
- R8: While flush is 1, a register stays busy after the edge only if it was busy, its keep-mask bit is 1, and no valid write-back names it. Allocations in a flush cycle are dropped.
- R9: A register that no allocation, write-back or flush touches keeps its value.
- R10: Reset wins over allocation. A register allocated in a reset cycle reads not-busy afterwards.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alloc_valid_i | input | 2 | Per allocate port: a new destination is assigned this cycle |
| alloc_preg_i | input | 2x6 | Per allocate port: physical register number |
| wb_valid_i | input | 2 | Per write-back port: a result is written this cycle |
| wb_preg_i | input | 2x6 | Per write-back port: physical register number |
| flush_i | input | 1 | Drop pending registers not named in the keep mask |
| keep_mask_i | input | 64 | One bit per register: 1 keeps its busy state during a flush |
| rd_preg_i | input | 4x6 | Per read port: physical register number looked up at decode |
| busy_o | output | 4 | Per read port: 1 if the register is still pending |

## Verification
The assertions expect the allocate ports never to name a register that is already busy and never to name the same register twice in one cycle. A correct free list guarantees both, but the properties on set, clear and hold stay valid even if this is broken. They do not assume that write-backs target only busy registers. The stimulus table allocates only registers that are free at that point of the sequence. Re-allocation happens only after a write-back or a flush has released the register. Where an invalid port is exercised, it carries a register number that differs from the valid one.

// File: rtl/pbt_pkg.sv
package pbt_pkg;
  localparam int PBT_NPREGS   = 64;
  localparam int PBT_ALLOC_N  = 2;
  localparam int PBT_WB_N     = 2;
  localparam int PBT_READ_N   = 4;
endpackage

// File: rtl/pbt_port_decode.sv
module pbt_port_decode #(
  parameter int NPREGS = 64,
  parameter int PORTS  = 2,
  localparam int PW    = $clog2(NPREGS)
) (
  input  logic [PORTS-1:0]         valid_i,
  input  logic [PORTS-1:0][PW-1:0] preg_i,
  output logic [NPREGS-1:0]        hit_o
);
  logic [PORTS-1:0][NPREGS-1:0] port_hit;

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    always_comb begin
      port_hit[p] = '0;
      if (valid_i[p]) port_hit[p][preg_i[p]] = 1'b1;
    end
  end

  always_comb begin
    hit_o = '0;
    for (int p = 0; p < PORTS; p++) hit_o = hit_o | port_hit[p];
  end
endmodule

// File: rtl/pbt_state.sv
module pbt_state #(
  parameter int NPREGS = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPREGS-1:0] set_vec,
  input  logic [NPREGS-1:0] clr_vec,
  input  logic              flush_i,
  input  logic [NPREGS-1:0] keep_i,
  output logic [NPREGS-1:0] busy_q
);
  always_ff @(posedge clk) begin
    if (rst)          busy_q <= '0;
    else if (flush_i) busy_q <= busy_q & keep_i & ~clr_vec;
    else              busy_q <= (busy_q & ~clr_vec) | set_vec;
  end

  // R2 R4
  alloc_sets_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_i |=> ((busy_q & $past(set_vec)) == $past(set_vec)));

  // R3
  wb_clears_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((busy_q & $past(clr_vec) & ~$past(set_vec)) == '0));

  // R8
  flush_keep_chk: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> (busy_q == ($past(busy_q) & $past(keep_i) & ~$past(clr_vec))));

  // R9
  untouched_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !flush_i |=> (((busy_q ^ $past(busy_q)) & ~($past(set_vec) | $past(clr_vec))) == '0));
endmodule

// File: rtl/pbt_read_port.sv
module pbt_read_port #(
  parameter int NPREGS = 64,
  localparam int PW    = $clog2(NPREGS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NPREGS-1:0] busy_vec,
  input  logic [NPREGS-1:0] clr_vec,
  input  logic [PW-1:0]     preg_i,
  output logic              busy_o
);
  logic stored_bit;
  logic wb_hit;

  assign stored_bit = busy_vec[preg_i];
  assign wb_hit     = clr_vec[preg_i];
  assign busy_o     = stored_bit & ~wb_hit;

  // R6
  wb_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    wb_hit |-> !busy_o);

  // R5
  stored_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (stored_bit && !wb_hit) |-> busy_o);
endmodule

// File: rtl/pbt_busy_table.sv
module pbt_busy_table #(
  parameter int NPREGS  = pbt_pkg::PBT_NPREGS,
  parameter int ALLOC_N = pbt_pkg::PBT_ALLOC_N,
  parameter int WB_N    = pbt_pkg::PBT_WB_N,
  parameter int READ_N  = pbt_pkg::PBT_READ_N,
  localparam int PW     = $clog2(NPREGS)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [ALLOC_N-1:0]         alloc_valid_i,
  input  logic [ALLOC_N-1:0][PW-1:0] alloc_preg_i,
  input  logic [WB_N-1:0]            wb_valid_i,
  input  logic [WB_N-1:0][PW-1:0]    wb_preg_i,
  input  logic                       flush_i,
  input  logic [NPREGS-1:0]          keep_mask_i,
  input  logic [READ_N-1:0][PW-1:0]  rd_preg_i,
  output logic [READ_N-1:0]          busy_o
);
  logic [NPREGS-1:0] set_vec;
  logic [NPREGS-1:0] clr_vec;
  logic [NPREGS-1:0] busy_q;

  pbt_port_decode #(.NPREGS(NPREGS), .PORTS(ALLOC_N)) u_alloc_dec (
    .valid_i (alloc_valid_i),
    .preg_i  (alloc_preg_i),
    .hit_o   (set_vec)
  );

  pbt_port_decode #(.NPREGS(NPREGS), .PORTS(WB_N)) u_wb_dec (
    .valid_i (wb_valid_i),
    .preg_i  (wb_preg_i),
    .hit_o   (clr_vec)
  );

  pbt_state #(.NPREGS(NPREGS)) u_state (
    .clk     (clk),
    .rst     (rst),
    .set_vec (set_vec),
    .clr_vec (clr_vec),
    .flush_i (flush_i),
    .keep_i  (keep_mask_i),
    .busy_q  (busy_q)
  );

  for (genvar r = 0; r < READ_N; r++) begin : g_rd
    pbt_read_port #(.NPREGS(NPREGS)) u_rd (
      .clk      (clk),
      .rst      (rst),
      .busy_vec (busy_q),
      .clr_vec  (clr_vec),
      .preg_i   (rd_preg_i[r]),
      .busy_o   (busy_o[r])
    );
  end

  // R10
  reset_clears_chk: assert property (@(posedge clk)
    rst |=> (busy_q == '0));
endmodule

// File: tb/test_pbt_busy_table.sv
`timescale 1ns/1ps
module test_pbt_busy_table;
  localparam int NPR = 64;
  localparam int PW  = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [1:0]      alloc_valid_i;
  logic [1:0][5:0] alloc_preg_i;
  logic [1:0]      wb_valid_i;
  logic [1:0][5:0] wb_preg_i;
  logic            flush_i;
  logic [NPR-1:0]  keep_mask_i;
  logic [3:0][5:0] rd_preg_i;
  logic [3:0]      busy_o;

  int n_tests = 0;
  int n_fail  = 0;

  always #2 clk = ~clk;

  pbt_busy_table i_pbt_busy_table (
    .clk(clk), .rst(rst),
    .alloc_valid_i(alloc_valid_i), .alloc_preg_i(alloc_preg_i),
    .wb_valid_i(wb_valid_i), .wb_preg_i(wb_preg_i),
    .flush_i(flush_i), .keep_mask_i(keep_mask_i),
    .rd_preg_i(rd_preg_i), .busy_o(busy_o)
  );

  typedef struct packed {
    logic [1:0] av; logic [5:0] a0; logic [5:0] a1;
    logic [1:0] wv; logic [5:0] w0; logic [5:0] w1;
    logic [5:0] r0; logic [5:0] r1; logic [5:0] r2; logic [5:0] r3;
    logic [3:0] exp;
  } vec_t;

  // exp bit i belongs to read port i; checked in the cycle the vector is driven
  localparam vec_t VEC [8] = '{
    '{2'b11, 6'd5,  6'd9,  2'b00, 6'd0,  6'd0, 6'd5,  6'd9,  6'd0,  6'd63, 4'b0000}, // R2 R7
    '{2'b01, 6'd63, 6'd0,  2'b00, 6'd0,  6'd0, 6'd5,  6'd9,  6'd63, 6'd1,  4'b0011}, // R2 R5
    '{2'b00, 6'd0,  6'd0,  2'b01, 6'd5,  6'd0, 6'd5,  6'd9,  6'd63, 6'd5,  4'b0110}, // R6
    '{2'b10, 6'd7,  6'd5,  2'b10, 6'd63, 6'd9, 6'd5,  6'd9,  6'd63, 6'd7,  4'b0100}, // R3 R6
    '{2'b01, 6'd20, 6'd0,  2'b01, 6'd20, 6'd0, 6'd20, 6'd5,  6'd63, 6'd7,  4'b0110}, // R4 R2
    '{2'b00, 6'd0,  6'd0,  2'b00, 6'd0,  6'd0, 6'd20, 6'd5,  6'd63, 6'd7,  4'b0111}, // R4 R9
    '{2'b00, 6'd0,  6'd0,  2'b11, 6'd20, 6'd63,6'd20, 6'd63, 6'd5,  6'd0,  4'b0100}, // R3
    '{2'b00, 6'd0,  6'd0,  2'b00, 6'd0,  6'd0, 6'd20, 6'd63, 6'd5,  6'd0,  4'b0100}  // R3 R9
  };

  task automatic drive_idle();
    alloc_valid_i = '0; alloc_preg_i = '0;
    wb_valid_i = '0; wb_preg_i = '0;
    flush_i = 1'b0; keep_mask_i = '0;
    rd_preg_i = '0;
  endtask

  task automatic set_reads(input logic [5:0] a, input logic [5:0] b,
                           input logic [5:0] c, input logic [5:0] d);
    rd_preg_i[0] = a; rd_preg_i[1] = b; rd_preg_i[2] = c; rd_preg_i[3] = d;
  endtask

  task automatic check_rd(input logic [3:0] exp, input string req);
    #1;
    n_tests++;
    if (busy_o !== exp) begin
      n_fail++;
      $display("FAIL %s: busy_o=%b expected %b", req, busy_o, exp);
    end
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog: run did not complete, got timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    drive_idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R1: every register reads not-busy after reset
    for (int g = 0; g < NPR / 4; g++) begin
      set_reads(PW'(g*4), PW'(g*4+1), PW'(g*4+2), PW'(g*4+3));
      check_rd(4'b0000, "R1");
    end

    // R2 R3 R4 R5 R6 R7 R9: vector table
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      alloc_valid_i   = VEC[i].av;
      alloc_preg_i[0] = VEC[i].a0; alloc_preg_i[1] = VEC[i].a1;
      wb_valid_i      = VEC[i].wv;
      wb_preg_i[0]    = VEC[i].w0; wb_preg_i[1] = VEC[i].w1;
      set_reads(VEC[i].r0, VEC[i].r1, VEC[i].r2, VEC[i].r3);
      check_rd(VEC[i].exp, $sformatf("R5 vector %0d", i));
    end

    // R8: flush with keep mask; state before is {5}
    @(negedge clk); drive_idle();
    alloc_valid_i = 2'b11; alloc_preg_i[0] = 6'd1; alloc_preg_i[1] = 6'd2;
    @(negedge clk); drive_idle();
    alloc_valid_i = 2'b01; alloc_preg_i[0] = 6'd3;
    @(negedge clk); drive_idle();
    flush_i = 1'b1;
    keep_mask_i[1] = 1'b1; keep_mask_i[2] = 1'b1; keep_mask_i[40] = 1'b1;
    alloc_valid_i = 2'b01; alloc_preg_i[0] = 6'd50;
    wb_valid_i = 2'b01; wb_preg_i[0] = 6'd2;
    set_reads(6'd2, 6'd1, 6'd3, 6'd50);
    check_rd(4'b0110, "R8 during flush");
    @(negedge clk); drive_idle();
    set_reads(6'd1, 6'd2, 6'd3, 6'd40);
    check_rd(4'b0001, "R8 kept/dropped");
    set_reads(6'd50, 6'd5, 6'd0, 6'd63);
    check_rd(4'b0000, "R8 alloc ignored in flush");

    // R10: reset overrides allocation
    @(negedge clk);
    alloc_valid_i = 2'b11; alloc_preg_i[0] = 6'd10; alloc_preg_i[1] = 6'd11;
    @(negedge clk); drive_idle();
    set_reads(6'd10, 6'd11, 6'd1, 6'd12);
    check_rd(4'b0111, "R2 before reset");
    rst = 1'b1;
    alloc_valid_i = 2'b01; alloc_preg_i[0] = 6'd12;
    @(negedge clk); drive_idle();
    rst = 1'b0;
    set_reads(6'd10, 6'd11, 6'd12, 6'd1);
    check_rd(4'b0000, "R10");

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule